// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two data ports, A and B, through two storage banks of WIDTH bits each. One bank carries data from A to B and the other carries data from B to A. Each direction has three active-low controls: a path enable, a capture control and an output enable. Together they decide when the bank follows its input bus, when it freezes, and when the far port is driven. A parameter picks whether both directions pass data unchanged or complemented. Tri-state pins are not modelled: each port has a data-out bus and a drive-enable flag, which surrounding pad logic combines into a real bus.

Capture is synchronous. On every clock edge, each direction's controller moves into one of three named states, computed from the controls present at that edge:
- PS_DISABLED: the path enable is high.
- PS_TRANSPARENT: the path enable is low and the capture control is low. The bank loads its input bus at that edge.
- PS_HOLD: the path enable is low and the capture control is high. The bank keeps its contents.

The named transitions are as follows. *open* leads from any state into PS_TRANSPARENT. *freeze* leads from PS_TRANSPARENT into PS_HOLD when the capture control rises. *close* leads from any state into PS_DISABLED when the path enable rises. *resume* leads from PS_DISABLED into PS_HOLD. The synchronous reset forces PS_DISABLED and clears both banks to zero. A registered copy of the output enable qualifies the drive flag. The drive flag is set only when the state is not PS_DISABLED and that registered copy is low.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge both banks hold zero, so `a_out` and `b_out` read 0 when INVERT=0, and `a_drive` and `b_drive` are 0.
- R2: At an edge where `ab_en_n`=0 and `ab_le_n`=0, the A-to-B bank loads `a_in`, and `b_out` shows the new value after that edge.
- R3: At an edge where `ab_en_n`=0 and `ab_le_n`=1, the A-to-B bank holds, and `b_out` does not change when `a_in` changes.
- R4: At an edge where `ab_en_n`=1, the A-to-B bank holds whatever the value of `ab_le_n`. A rise of the path enable therefore closes capture just as a rise of the capture control does.
- R5: After an edge, `b_drive` is 1 exactly when `ab_en_n`=0 and `ab_oe_n`=0 were sampled at that edge. `a_drive` follows `ba_en_n` and `ba_oe_n` in the same way.
- R6: `ab_oe_n` has no effect on storage. `b_out` still reports the bank while `b_drive` is 0, and loading proceeds when `ab_oe_n`=1.
- R7: The B-to-A direction behaves like R2 to R4 using `ba_en_n`, `ba_le_n`, `b_in` and `a_out`.
- R8: Activity in one direction never changes the other direction's bank or drive flag.
- R9: With INVERT=1, `b_out` is the bitwise complement of the stored `a_in` value and `a_out` is the complement of the stored `b_in` value. With INVERT=0, both outputs equal the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Data arriving on port A |
| b_in | input | WIDTH | Data arriving on port B |
| ab_en_n | input | 1 | A-to-B path enable, active low |
| ab_le_n | input | 1 | A-to-B capture control, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A path enable, active low |
| ba_le_n | input | 1 | B-to-A capture control, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | WIDTH | Data presented to port A (from the B-to-A bank) |
| a_drive | output | 1 | Port A drive flag |
| b_out | output | WIDTH | Data presented to port B (from the A-to-B bank) |
| b_drive | output | 1 | Port B drive flag |

## Verification
Every result lands exactly one clock edge after the controls and data that cause it. This covers bank loads, holds, drive flags and the reset clear, because each passes through a single register. The bench changes inputs 1 ns after a rising edge and then waits for the next rising edge. It samples 1 ns after that edge, so each check reads the value produced by precisely one edge. Hold and no-effect cases first change the input data and then read the unchanged output on the following sample.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        PS_DISABLED    = 2'd0,
        PS_TRANSPARENT = 2'd1,
        PS_HOLD        = 2'd2
    } path_state_t;

    // Next state of one direction from its active-low controls.
    function automatic path_state_t path_next(input logic en_n, input logic le_n);
        path_state_t nxt;
        if (en_n)
            nxt = PS_DISABLED;
        else if (!le_n)
            nxt = PS_TRANSPARENT;
        else
            nxt = PS_HOLD;
        return nxt;
    endfunction

endpackage

// File: rtl/xcvr_path_ctl.sv
module xcvr_path_ctl
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    input  logic le_n,
    input  logic oe_n,
    output logic load,
    output logic drive
);

    path_state_t state_q;
    path_state_t state_d;
    logic        oe_n_q;

    always_comb begin
        state_d = path_next(en_n, le_n);
        load    = !rst && (state_d == PS_TRANSPARENT);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_DISABLED;
            oe_n_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            oe_n_q  <= oe_n;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            PS_DISABLED:    drive = 1'b0;
            PS_TRANSPARENT: drive = !oe_n_q;
            PS_HOLD:        drive = !oe_n_q;
            default:        drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst)
            store_q <= '0;
        else if (load)
            store_q <= din;
    end

    generate
        if (INVERT) begin : g_inv
            assign dout = ~store_q;
        end else begin : g_pass
            assign dout = store_q;
        end
    endgenerate

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ab_en_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_en_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive
);

    logic ab_load;
    logic ba_load;

    xcvr_path_ctl u_ab_ctl (
        .clk   (clk),
        .rst   (rst),
        .en_n  (ab_en_n),
        .le_n  (ab_le_n),
        .oe_n  (ab_oe_n),
        .load  (ab_load),
        .drive (b_drive)
    );

    xcvr_bank #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ab_bank (
        .clk  (clk),
        .rst  (rst),
        .load (ab_load),
        .din  (a_in),
        .dout (b_out)
    );

    xcvr_path_ctl u_ba_ctl (
        .clk   (clk),
        .rst   (rst),
        .en_n  (ba_en_n),
        .le_n  (ba_le_n),
        .oe_n  (ba_oe_n),
        .load  (ba_load),
        .drive (a_drive)
    );

    xcvr_bank #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ba_bank (
        .clk  (clk),
        .rst  (rst),
        .load (ba_load),
        .din  (b_in),
        .dout (a_out)
    );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             ab_en_n,
    input logic             ab_le_n,
    input logic             ab_oe_n,
    input logic             ba_en_n,
    input logic             ba_le_n,
    input logic             ba_oe_n,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drive,
    input logic [WIDTH-1:0] b_out,
    input logic             b_drive
);

    localparam logic [WIDTH-1:0] POL = INVERT ? '1 : '0;

    assert_reset_drive_R1: assert property (@(posedge clk)
        rst |=> (!a_drive && !b_drive));

    assert_ab_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && !ab_le_n) |=> (b_out == ($past(a_in) ^ POL)));

    assert_ab_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ab_en_n || ab_le_n) |=> $stable(b_out));

    assert_b_drive_on_R5: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && !ab_oe_n) |=> b_drive);

    assert_b_drive_off_R5: assert property (@(posedge clk) disable iff (rst)
        (ab_en_n || ab_oe_n) |=> !b_drive);

    assert_ba_load_R7: assert property (@(posedge clk) disable iff (rst)
        (!ba_en_n && !ba_le_n) |=> (a_out == ($past(b_in) ^ POL)));

    assert_ba_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ba_en_n || ba_le_n) |=> $stable(a_out));

    assert_a_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (ba_en_n || ba_oe_n) |=> !a_drive);

endmodule

bind bidir_latch_xcvr xcvr_checker #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .ab_en_n (ab_en_n),
    .ab_le_n (ab_le_n),
    .ab_oe_n (ab_oe_n),
    .ba_en_n (ba_en_n),
    .ba_le_n (ba_le_n),
    .ba_oe_n (ba_oe_n),
    .a_out   (a_out),
    .a_drive (a_drive),
    .b_out   (b_out),
    .b_drive (b_drive)
);

// File: tb/bidir_latch_xcvr_test.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
    logic [W-1:0] a_out, b_out, a_out_i, b_out_i;
    logic a_drive, b_drive, a_drive_i, b_drive_i;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bidir_latch_xcvr #(.WIDTH(W), .INVERT(1'b0)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive));

    bidir_latch_xcvr #(.WIDTH(W), .INVERT(1'b1)) uut_inv (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out_i), .a_drive(a_drive_i), .b_out(b_out_i), .b_drive(b_drive_i));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock edge, then sample 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_all();
        ab_en_n = 1'b1; ab_le_n = 1'b1; ab_oe_n = 1'b1;
        ba_en_n = 1'b1; ba_le_n = 1'b1; ba_oe_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        check("R1 b_out", b_out, 0);
        check("R1 a_out", a_out, 0);
        check("R1 drives", {a_drive, b_drive}, 0);
        rst = 1'b0;
    endtask

    task automatic t_ab_transparent();
        logic [W-1:0] pats [4] = '{8'h5A, 8'hA5, 8'hFF, 8'h01};
        ab_en_n = 1'b0; ab_le_n = 1'b0; ab_oe_n = 1'b0;
        foreach (pats[i]) begin
            a_in = pats[i];
            tick();
            check("R2 b_out follows a_in", b_out, pats[i]);
            check("R5 b_drive on", b_drive, 1);
        end
    endtask

    task automatic t_ab_hold();
        a_in = 8'h3C;
        tick();
        ab_le_n = 1'b1;
        a_in = 8'hC3;
        tick();
        check("R3 hold after freeze", b_out, 8'h3C);
        a_in = 8'h77;
        tick();
        check("R3 hold stays", b_out, 8'h3C);
        check("R5 b_drive in hold", b_drive, 1);
    endtask

    task automatic t_ab_close_by_en();
        ab_le_n = 1'b0; a_in = 8'h12;
        tick();
        check("R2 reload", b_out, 8'h12);
        ab_en_n = 1'b1; a_in = 8'h99;
        tick();
        check("R4 en high blocks load", b_out, 8'h12);
        check("R5 b_drive off with en high", b_drive, 0);
        ab_le_n = 1'b1; a_in = 8'h44;
        tick();
        check("R4 still blocked", b_out, 8'h12);
    endtask

    task automatic t_oe_no_effect();
        ab_en_n = 1'b0; ab_le_n = 1'b0; ab_oe_n = 1'b1; a_in = 8'hE7;
        tick();
        check("R6 load with oe high", b_out, 8'hE7);
        check("R5 b_drive off with oe high", b_drive, 0);
        ab_oe_n = 1'b0;
        tick();
        check("R5 b_drive returns", b_drive, 1);
        idle_all();
        tick();
    endtask

    task automatic t_ba_path();
        logic [W-1:0] before_b;
        before_b = b_out;
        ba_en_n = 1'b0; ba_le_n = 1'b0; ba_oe_n = 1'b0; b_in = 8'h6D;
        tick();
        check("R7 a_out follows b_in", a_out, 8'h6D);
        check("R5 a_drive on", a_drive, 1);
        check("R8 ab bank untouched", b_out, before_b);
        check("R8 b_drive untouched", b_drive, 0);
        ba_le_n = 1'b1; b_in = 8'h00;
        tick();
        check("R7 hold", a_out, 8'h6D);
        ba_en_n = 1'b1; ba_le_n = 1'b0; b_in = 8'hF0;
        tick();
        check("R7 en high blocks", a_out, 8'h6D);
        check("R5 a_drive off", a_drive, 0);
        idle_all();
    endtask

    task automatic t_invert();
        ab_en_n = 1'b0; ab_le_n = 1'b0; a_in = 8'hA0;
        ba_en_n = 1'b0; ba_le_n = 1'b0; b_in = 8'h0F;
        tick();
        check("R9 invert b_out", b_out_i, 8'h5F);
        check("R9 invert a_out", a_out_i, 8'hF0);
        check("R9 pass b_out", b_out, 8'hA0);
        check("R9 pass a_out", a_out, 8'h0F);
        idle_all();
        tick();
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        tick();
        check("R1 clear b_out", b_out, 0);
        check("R1 clear a_out", a_out, 0);
        check("R1 invert clear", b_out_i, 8'hFF);
        rst = 1'b0;
        tick();
    endtask

    initial begin
        #1;
        t_reset();
        t_ab_transparent();
        t_ab_hold();
        t_ab_close_by_en();
        t_oe_no_effect();
        t_ba_path();
        t_invert();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule